// File: doc/BRIEF.md
# Interlaced Composite Sync Generator

This block turns a master clock running at 32 times the line rate into a 2:1 interlaced mixed sync waveform for a 525-line or 625-line raster. A horizontal counter splits each line into two half-line slots of 16 clocks. A half-line counter walks through the frame: 1050 slots in 525 mode, 1250 in 625 mode. A composite decoder turns the two counts into the sync level for each clock.

Each field opens with a vertical interval of eighteen half-line slots: six narrow equalizing pulses, six broad serrated pulses, then six more equalizing pulses. The second field's interval starts one odd half-line later than a whole number of lines, which gives the interlace. The block also drives a plain line-rate horizontal sync, a field parity flag and a one-clock frame marker. Two active-low strobes let external logic move the vertical position to a fixed point of the interval. The move takes effect at the next line boundary, so horizontal phase is never disturbed.

Top module: `interlaced_sync_gen`

## Requirements
- R1: A line lasts exactly 32 clocks, and `hsync_n` is low for the first 2 clocks of every line, in both fields and in every part of the frame.
- R2: On a line outside both vertical intervals, `csync_n` is low for the first 2 clocks of the line and high for the other 30.
- R3: In the equalizing slots, `csync_n` is low only on the first clock of each 16-clock half-line slot. These are slots 0 to 5 and 12 to 17, counted from the start of a field's vertical interval.
- R4: In the broad slots (slots 6 to 11 of the interval), `csync_n` is low for the first 14 clocks of each half-line slot and high for the last 2 (the serration).
- R5: When `mode_625` is high, a frame is 625 lines (1250 half-lines); when it is low, a frame is 525 lines (1050 half-lines). The input is sampled only to choose the frame length and field boundary.
- R6: The second field's vertical interval starts exactly L half-lines (L×16 clocks) after the first field's, where L is the line count. `field_odd` is high for the first L half-lines of the frame and low for the rest.
- R7: `frame_sync` is high for exactly one clock, the same clock as the first equalizing pulse of the odd field, and never in the even field.
- R8: All outputs are registered. During a synchronous reset (`rst_n` low at a clock edge) they idle at `csync_n`=1, `hsync_n`=1, `field_odd`=1, `frame_sync`=0. The first clock after release carries the first equalizing pulse of the odd field, with `frame_sync` high.
- R9: A falling edge on `vres_eq_n` is passed through a two-flop synchronizer and held as a request. At the next line boundary, the next line starts at the first equalizing pulse of the odd field (half-line 0).
- R10: A falling edge on `vres_vs_n` is handled the same way. At the next line boundary, the next line starts at the first broad pulse of the odd field (half-line 6), with no `frame_sync`.
- R11: If both requests are pending at the same line boundary, the equalizing-pulse reset wins.
- R12: Counted over one frame, `csync_n` has L+18 falling edges and 12 broad low runs of 14 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 32 cycles per line |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_625 | input | 1 | 1 selects 625 lines, 0 selects 525 lines |
| vres_eq_n | input | 1 | Active-low strobe: restart at the first equalizing pulse |
| vres_vs_n | input | 1 | Active-low strobe: restart at the first broad pulse |
| csync_n | output | 1 | Mixed sync, active low |
| hsync_n | output | 1 | Horizontal sync, active low, every line |
| field_odd | output | 1 | High during the odd (first) field |
| frame_sync | output | 1 | One-clock pulse at the start of each odd field |

## Verification
Two vertical-position requests can be pending at the same line boundary. The bench provokes this by dropping `vres_eq_n` and `vres_vs_n` together in the middle of a line. The expected result is a `frame_sync` pulse shortly after the boundary and no broad pulse, which shows the equalizing reset won. A reference model in the bench tracks both pending requests from the pins and is compared with all four outputs on every clock. A wrong priority or a request applied in the wrong cycle therefore shows up as a waveform mismatch as well.

// File: rtl/sync_gen_pkg.sv
// Package: shared types for the interlaced sync generator.
// Assumes: nothing beyond IEEE 1800-2017.
package sync_gen_pkg;

    // Kind of half-line slot the decoder is currently in.
    typedef enum logic [1:0] {
        SEG_NORMAL = 2'd0,
        SEG_EQ     = 2'd1,
        SEG_BROAD  = 2'd2
    } seg_t;

endpackage

// File: rtl/sg_vres_sync.sv
// Module: sg_vres_sync
// Synchronizes one active-low strobe, detects its falling edge and keeps a
// request until the timebase consumes it at a line boundary.
// Assumes: the strobe is held low for at least one clock; consume is a
// single-cycle pulse from the timebase.
module sg_vres_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic consume,
    output logic req
);
    localparam int unsigned CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;
    logic             pend_q;
    logic             fall;

    // Shift the strobe through the synchronizer plus one edge-detect stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[CHAIN-2:0], pin_n};
    end

    assign fall = chain_q[CHAIN-1] & ~chain_q[CHAIN-2];

    // Hold a detected edge until the next line boundary takes it.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (consume) pend_q <= 1'b0;
        else if (fall)    pend_q <= 1'b1;
    end

    assign req = pend_q | fall;

    // A request consumed at a boundary is gone on the next clock (R9).
    p_req_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> !pend_q);

endmodule

// File: rtl/sg_timebase.sv
// Module: sg_timebase
// Horizontal clock counter and half-line counter of the frame. Position loads
// are applied only at the end of a line so horizontal phase is continuous.
// Assumes: CLK_PER_LINE is even; mode_625 is stable within a frame.
module sg_timebase #(
    parameter int unsigned CLK_PER_LINE = 32,
    parameter int unsigned LINES_A      = 525,
    parameter int unsigned LINES_B      = 625,
    parameter int unsigned VS_SLOT      = 6
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    mode_625,
    input  logic                                    load_eq,
    input  logic                                    load_vs,
    output logic [$clog2(CLK_PER_LINE)-1:0]         h,
    output logic [$clog2(2*LINES_B)-1:0]            hl,
    output logic                                    line_end
);
    localparam int unsigned H_W  = $clog2(CLK_PER_LINE);
    localparam int unsigned HL_W = $clog2(2*LINES_B);
    localparam int unsigned HALF = CLK_PER_LINE / 2;

    logic            half_end;
    logic [HL_W-1:0] hl_last;

    assign line_end = (h == H_W'(CLK_PER_LINE - 1));
    assign half_end = (h == H_W'(HALF - 1));
    assign hl_last  = mode_625 ? HL_W'(2*LINES_B - 1) : HL_W'(2*LINES_A - 1);

    // Advance the clock-within-line counter.
    always_ff @(posedge clk) begin
        if (!rst_n)        h <= '0;
        else if (line_end) h <= '0;
        else               h <= h + 1'b1;
    end

    // Advance the half-line counter, taking position loads at line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hl <= '0;
        end else if (line_end) begin
            if (load_eq)             hl <= '0;
            else if (load_vs)        hl <= HL_W'(VS_SLOT);
            else if (hl == hl_last)  hl <= '0;
            else                     hl <= hl + 1'b1;
        end else if (half_end) begin
            hl <= hl + 1'b1;
        end
    end

    // The half-line count stays inside the selected frame (R5).
    p_hl_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hl <= hl_last);

    // Equalizing restart wins over broad restart at one boundary (R11).
    p_load_priority_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && load_eq && load_vs) |=> (hl == '0 && h == '0));

    // A lone broad restart lands on the first broad slot (R10).
    p_vs_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && load_vs && !load_eq) |=> (hl == HL_W'(VS_SLOT)));

    // A line wraps after exactly CLK_PER_LINE clocks (R1).
    p_line_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (h == '0));

endmodule

// File: rtl/sg_decoder.sv
// Module: sg_decoder
// Composite decoder: maps the clock and half-line counts to mixed sync,
// horizontal sync, field parity and the frame marker, all retimed by a
// register on the master clock.
// Assumes: counts come from sg_timebase with the same parameters.
module sg_decoder
    import sync_gen_pkg::*;
#(
    parameter int unsigned CLK_PER_LINE = 32,
    parameter int unsigned LINES_A      = 525,
    parameter int unsigned LINES_B      = 625,
    parameter int unsigned EQ_SLOTS     = 6,
    parameter int unsigned BROAD_SLOTS  = 6,
    parameter int unsigned HSYNC_W      = 2,
    parameter int unsigned EQ_W         = 1,
    parameter int unsigned BROAD_W      = 14
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                mode_625,
    input  logic [$clog2(CLK_PER_LINE)-1:0]     h,
    input  logic [$clog2(2*LINES_B)-1:0]        hl,
    output logic                                csync_n,
    output logic                                hsync_n,
    output logic                                field_odd,
    output logic                                frame_sync
);
    localparam int unsigned H_W    = $clog2(CLK_PER_LINE);
    localparam int unsigned HL_W   = $clog2(2*LINES_B);
    localparam int unsigned HALF   = CLK_PER_LINE / 2;
    localparam int unsigned VI_LEN = 2*EQ_SLOTS + BROAD_SLOTS;

    logic [HL_W-1:0] lines;
    logic [H_W-1:0]  pos;
    logic            in_f1;
    logic            in_f2;
    logic [HL_W-1:0] slot;
    seg_t            seg;
    logic            sync_low;

    assign lines = mode_625 ? HL_W'(LINES_B) : HL_W'(LINES_A);

    // Position inside the current half-line slot.
    always_comb begin
        if (h >= H_W'(HALF)) pos = h - H_W'(HALF);
        else                 pos = h;
    end

    // Classify the current slot as normal, equalizing or broad.
    always_comb begin
        in_f1 = (hl < HL_W'(VI_LEN));
        in_f2 = (hl >= lines) && (hl < lines + HL_W'(VI_LEN));
        slot  = in_f1 ? hl : (hl - lines);
        if (!(in_f1 || in_f2))
            seg = SEG_NORMAL;
        else if (slot >= HL_W'(EQ_SLOTS) && slot < HL_W'(EQ_SLOTS + BROAD_SLOTS))
            seg = SEG_BROAD;
        else
            seg = SEG_EQ;
    end

    // Pick the sync level for this clock from the slot kind.
    always_comb begin
        unique case (seg)
            SEG_BROAD: sync_low = (pos < H_W'(BROAD_W));
            SEG_EQ:    sync_low = (pos < H_W'(EQ_W));
            default:   sync_low = (h < H_W'(HSYNC_W));
        endcase
    end

    // Retime all outputs on the master clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csync_n    <= 1'b1;
            hsync_n    <= 1'b1;
            field_odd  <= 1'b1;
            frame_sync <= 1'b0;
        end else begin
            csync_n    <= ~sync_low;
            hsync_n    <= ~(h < H_W'(HSYNC_W));
            field_odd  <= (hl < lines);
            frame_sync <= (hl == '0) && (h == '0);
        end
    end

    // The last clock of a broad slot is a serration, so sync is high (R4).
    p_broad_notch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seg == SEG_BROAD && pos == H_W'(HALF - 1)) |=> csync_n);

    // The frame marker is a single clock wide (R7).
    p_fs_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> !frame_sync);

    // The frame marker sits on an equalizing pulse of the odd field (R7).
    p_fs_odd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |-> (field_odd && !csync_n));

    // Horizontal sync is never a single clock wide (R1).
    p_hsync_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync_n) |=> !hsync_n);

endmodule

// File: rtl/interlaced_sync_gen.sv
// Module: interlaced_sync_gen
// Top level: two strobe synchronizers, the frame timebase and the composite
// decoder. Produces interlaced mixed sync from a 32x line-rate clock.
// Assumes: clk is the master clock; rst_n is synchronous and active low.
module interlaced_sync_gen #(
    parameter int unsigned CLK_PER_LINE = 32,
    parameter int unsigned LINES_A      = 525,
    parameter int unsigned LINES_B      = 625,
    parameter int unsigned EQ_SLOTS     = 6,
    parameter int unsigned BROAD_SLOTS  = 6,
    parameter int unsigned HSYNC_W      = 2,
    parameter int unsigned EQ_W         = 1,
    parameter int unsigned BROAD_W      = 14,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_625,
    input  logic vres_eq_n,
    input  logic vres_vs_n,
    output logic csync_n,
    output logic hsync_n,
    output logic field_odd,
    output logic frame_sync
);
    localparam int unsigned H_W  = $clog2(CLK_PER_LINE);
    localparam int unsigned HL_W = $clog2(2*LINES_B);
    localparam int unsigned NREQ = 2;

    logic [NREQ-1:0] strobe_n;
    logic [NREQ-1:0] req;
    logic [H_W-1:0]  h;
    logic [HL_W-1:0] hl;
    logic            line_end;

    assign strobe_n = {vres_vs_n, vres_eq_n};

    // One synchronizer per position strobe; index 0 has priority.
    for (genvar i = 0; i < NREQ; i++) begin : g_vres
        sg_vres_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_n   (strobe_n[i]),
            .consume (line_end),
            .req     (req[i])
        );
    end

    sg_timebase #(
        .CLK_PER_LINE (CLK_PER_LINE),
        .LINES_A      (LINES_A),
        .LINES_B      (LINES_B),
        .VS_SLOT      (EQ_SLOTS)
    ) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_625 (mode_625),
        .load_eq  (req[0]),
        .load_vs  (req[1]),
        .h        (h),
        .hl       (hl),
        .line_end (line_end)
    );

    sg_decoder #(
        .CLK_PER_LINE (CLK_PER_LINE),
        .LINES_A      (LINES_A),
        .LINES_B      (LINES_B),
        .EQ_SLOTS     (EQ_SLOTS),
        .BROAD_SLOTS  (BROAD_SLOTS),
        .HSYNC_W      (HSYNC_W),
        .EQ_W         (EQ_W),
        .BROAD_W      (BROAD_W)
    ) u_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_625   (mode_625),
        .h          (h),
        .hl         (hl),
        .csync_n    (csync_n),
        .hsync_n    (hsync_n),
        .field_odd  (field_odd),
        .frame_sync (frame_sync)
    );

endmodule

// File: tb/interlaced_sync_gen_test.sv
`timescale 1ns/1ps
module interlaced_sync_gen_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_625 = 1'b0;
    logic vres_eq_n = 1'b1;
    logic vres_vs_n = 1'b1;
    logic csync_n, hsync_n, field_odd, frame_sync;

    int checks = 0;
    int failures = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    interlaced_sync_gen uut (
        .clk(clk), .rst_n(rst_n), .mode_625(mode_625),
        .vres_eq_n(vres_eq_n), .vres_vs_n(vres_vs_n),
        .csync_n(csync_n), .hsync_n(hsync_n),
        .field_odd(field_odd), .frame_sync(frame_sync)
    );

    // ---------------- reference model ----------------
    int m_h, m_hl, m_seg;
    bit m_pend_eq, m_pend_vs;
    bit e_cs, e_hs, e_fo, e_fs;

    function automatic int lines_now();
        return mode_625 ? 625 : 525;
    endfunction

    // 0 normal, 1 equalizing, 2 broad
    function automatic int seg_of(int hl, int lines);
        int k;
        if (hl < 18) k = hl;
        else if (hl >= lines && hl < lines + 18) k = hl - lines;
        else return 0;
        return (k >= 6 && k < 12) ? 2 : 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_h <= 0; m_hl <= 0; m_pend_eq <= 0; m_pend_vs <= 0;
            e_cs <= 1; e_hs <= 1; e_fo <= 1; e_fs <= 0; m_seg <= 0;
        end else begin
            int L, s, p;
            bit peq, pvs;
            L = lines_now();
            s = seg_of(m_hl, L);
            p = m_h % 16;
            m_seg <= s;
            e_cs <= (s == 2) ? (p >= 14) : (s == 1) ? (p >= 1) : (m_h >= 2);
            e_hs <= (m_h >= 2);
            e_fo <= (m_hl < L);
            e_fs <= (m_hl == 0 && m_h == 0);
            peq = m_pend_eq || !vres_eq_n;
            pvs = m_pend_vs || !vres_vs_n;
            if (m_h == 31) begin
                m_h <= 0;
                if (peq) m_hl <= 0;
                else if (pvs) m_hl <= 6;
                else m_hl <= (m_hl == 2*L - 1) ? 0 : m_hl + 1;
                m_pend_eq <= 0; m_pend_vs <= 0;
            end else begin
                m_h <= m_h + 1;
                if (m_h == 15) m_hl <= m_hl + 1;
                m_pend_eq <= peq; m_pend_vs <= pvs;
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, expv, $time);
        end
    endtask

    // Compare every output with the model on every clock.
    always @(negedge clk) begin
        if (cmp_en && rst_n && !done) begin
            chk(csync_n == e_cs,
                (m_seg == 2) ? "R4 csync broad" : (m_seg == 1) ? "R3 csync equalizing" : "R2 csync normal",
                csync_n, e_cs);
            chk(hsync_n == e_hs, "R1 hsync", hsync_n, e_hs);
            chk(field_odd == e_fo, "R6 field_odd", field_odd, e_fo);
            chk(frame_sync == e_fs, "R7 frame_sync", frame_sync, e_fs);
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // Reset, then watch two frames and tally pulses.
    task automatic run_frames(bit m);
        int L, falls, broads, run, fs_cnt, fo_fall;
        bit prev, prev_fo;
        L = m ? 625 : 525;
        @(negedge clk);
        cmp_en = 1'b0;
        rst_n = 1'b0;
        mode_625 = m;
        repeat (3) @(negedge clk);
        chk(csync_n == 1 && hsync_n == 1 && field_odd == 1 && frame_sync == 0,
            "R8 idle in reset", {csync_n, hsync_n, field_odd, frame_sync}, 4'b1110);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        falls = 0; broads = 0; run = 0; fs_cnt = 0; fo_fall = -1;
        prev = 1; prev_fo = 1;
        for (int n = 0; n < 2*L*32; n++) begin
            @(negedge clk);
            if (n == 0)
                chk(csync_n == 0 && frame_sync == 1, "R8 first clock after release",
                    {csync_n, frame_sync}, 2'b01);
            if (prev && !csync_n) falls++;
            if (!csync_n) run++;
            else begin
                if (run == 14) broads++;
                run = 0;
            end
            if (frame_sync) fs_cnt++;
            if (prev_fo && !field_odd && fo_fall < 0) fo_fall = n;
            prev = csync_n;
            prev_fo = field_odd;
        end
        chk(falls == 2*(L + 18), "R12 csync falling edges over two frames", falls, 2*(L + 18));
        chk(broads == 24, "R12 broad runs over two frames", broads, 24);
        chk(fs_cnt == 2, "R7 frame_sync pulses over two frames", fs_cnt, 2);
        chk(fo_fall == L*16, "R6 half-line field offset", fo_fall, L*16);
        chk(fo_fall == L*16, m ? "R5 625 field length" : "R5 525 field length", fo_fall, L*16);
    endtask

    // Drop the chosen strobes at clock 5 of a line, then watch 60 clocks.
    task automatic strobe(bit eq, bit vs, output bit fs_seen, output bit broad_seen);
        int run;
        @(negedge clk);
        while (m_h != 5) @(negedge clk);
        if (eq) vres_eq_n = 1'b0;
        if (vs) vres_vs_n = 1'b0;
        repeat (4) @(negedge clk);
        vres_eq_n = 1'b1;
        vres_vs_n = 1'b1;
        fs_seen = 0; broad_seen = 0; run = 0;
        for (int n = 0; n < 60; n++) begin
            @(negedge clk);
            if (frame_sync) fs_seen = 1;
            if (!csync_n) run++;
            else begin
                if (run == 14) broad_seen = 1;
                run = 0;
            end
        end
    endtask

    initial begin
        bit fs, br;
        run_frames(1'b0);
        run_frames(1'b1);
        run_frames(1'b0);
        repeat (3200) @(negedge clk);
        strobe(1, 0, fs, br);
        chk(fs, "R9 restart at first equalizing pulse", fs, 1);
        repeat (3200) @(negedge clk);
        strobe(0, 1, fs, br);
        chk(br, "R10 restart at first broad pulse", br, 1);
        chk(!fs, "R10 no frame_sync on broad restart", fs, 0);
        repeat (3200) @(negedge clk);
        strobe(1, 1, fs, br);
        chk(fs, "R11 equalizing restart wins", fs, 1);
        chk(!br, "R11 no broad pulse when both pending", br, 0);
        repeat (64) @(negedge clk);
        finish_run();
    end

endmodule